// File: doc/BRIEF.md
# Receive Status Flag Controller

This block keeps the receive-side status of an asynchronous serial receiver. The bit-level receiver upstream pulses `char_done` with a finished byte and pulses `idle_det` when the line has gone quiet. The controller holds the latest accepted byte and keeps three flags: receive data full, overrun and idle. It also drives an error interrupt request from the overrun flag when `ovr_ie` allows it.

Software clears the flags by reading in order. It first reads the status register, which is signalled by `stat_rd`, and then reads the data register, which is signalled by `data_rd`. Each status read records which flags were set at that moment. The next data read clears only those recorded flags and then discards the record. A byte that arrives while the held byte is still unread is dropped and raises overrun. The idle flag can only be raised after a byte has been accepted since reset, or since the idle flag was last raised.

Top module: `rx_status_flags`

## Requirements
- R1: A `char_done` pulse while `rx_full` is 1 (and not cleared in that cycle) sets `overrun` on the next cycle and leaves `rx_data` and `rx_full` unchanged.
- R2: `overrun` returns to 0 only on a `data_rd` cycle whose most recent earlier `stat_rd` saw `overrun` = 1, with no data read in between. A data read after a status read that saw `overrun` = 0 leaves it set.
- R3: `err_irq` is 1 exactly when `overrun` and `ovr_ie` are both 1, in the same cycle (default variant).
- R4: `idle_det` sets `idle` on the next cycle only if a byte has been accepted since reset or since `idle` was last set. Otherwise it has no effect.
- R5: While reset is asserted (`rst_n` = 0), `rx_full`, `overrun` and `idle` are 0.
- R6: If a byte arrives between the status read and the data read of a clearing sequence while the flags are set, the data read sees the older byte on `rx_data` and `overrun` stays 1. A following status read and data read then clear it.
- R7: `rx_full` clears on a `data_rd` whose preceding `stat_rd` saw `rx_full` = 1.
- R8: `idle` clears on a `data_rd` whose preceding `stat_rd` saw `idle` = 1.
- R9: A data read consumes the recorded flags, so a second `data_rd` with no new `stat_rd` clears nothing. A new `stat_rd` always records the flags again.
- R10: When `char_done` and a `data_rd` that clears `rx_full` fall in the same cycle, the new byte is loaded, `rx_full` stays 1 and `overrun` is not set.
- R11: An accepted byte appears on `rx_data`, with `rx_full` = 1, one clock after its `char_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_done | input | 1 | One-cycle pulse: a byte finished |
| char_data | input | DATA_W | Byte that goes with `char_done` |
| idle_det | input | 1 | One-cycle pulse: line found idle |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rx_full | output | 1 | Receive data full flag |
| overrun | output | 1 | Overrun flag |
| idle | output | 1 | Idle flag |
| rx_data | output | DATA_W | Held byte |
| err_irq | output | 1 | Error interrupt request |

## Verification
The assertions assume that `stat_rd` and `data_rd` are never both high in one cycle, which matches one bus access per cycle. They also assume every strobe is a single-cycle pulse. The random stimulus draws one bus access per cycle at most and raises `char_done` and `idle_det` independently. It also toggles `ovr_ie`, so collisions between arriving bytes and clearing reads occur often. The directed cases cover the delayed clearing sequence, the read-less double data read, and idle before any byte.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
   typedef struct packed {
      logic full;
      logic ovr;
      logic idle;
   } rxsf_flags_t;
endpackage

// File: rtl/rxsf_arm_capture.sv
module rxsf_arm_capture
   import rxsf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        stat_rd,
   input  logic        data_rd,
   input  rxsf_flags_t flags_q,
   output rxsf_flags_t armed_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       armed_q <= '0;
      else if (stat_rd) armed_q <= flags_q;
      else if (data_rd) armed_q <= '0;
   end
endmodule

// File: rtl/rxsf_flag_core.sv
module rxsf_flag_core
   import rxsf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        char_done,
   input  logic        idle_det,
   input  rxsf_flags_t clr,
   output rxsf_flags_t flags_q,
   output logic        load
);
   logic        full_kept;
   logic        idle_arm_q;
   rxsf_flags_t flags_d;

   always_comb begin
      full_kept     = flags_q.full & ~clr.full;
      load          = char_done & ~full_kept;
      flags_d.full  = full_kept | load;
      flags_d.ovr   = (flags_q.ovr & ~clr.ovr) | (char_done & full_kept);
      flags_d.idle  = (flags_q.idle & ~clr.idle) | (idle_det & idle_arm_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q    <= '0;
         idle_arm_q <= 1'b0;
      end else begin
         flags_q    <= flags_d;
         idle_arm_q <= load | (idle_arm_q & ~idle_det);
      end
   end
endmodule

// File: rtl/rxsf_data_hold.sv
module rxsf_data_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
   import rxsf_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              idle_det,
   input  logic              stat_rd,
   input  logic              data_rd,
   input  logic              ovr_ie,
   output logic              rx_full,
   output logic              overrun,
   output logic              idle,
   output logic [DATA_W-1:0] rx_data,
   output logic              err_irq
);
   initial begin
      if (DATA_W < 1 || DATA_W > 64)
         $error("rx_status_flags: DATA_W out of range");
   end

   rxsf_flags_t flags_q;
   rxsf_flags_t armed_q;
   rxsf_flags_t clr;
   logic        load;

   assign clr = data_rd ? armed_q : '0;

   rxsf_arm_capture u_arm (
      .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
      .flags_q(flags_q), .armed_q(armed_q));

   rxsf_flag_core u_core (
      .clk(clk), .rst_n(rst_n), .char_done(char_done), .idle_det(idle_det),
      .clr(clr), .flags_q(flags_q), .load(load));

   rxsf_data_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(load), .din(char_data), .dout(rx_data));

   assign rx_full = flags_q.full;
   assign overrun = flags_q.ovr;
   assign idle    = flags_q.idle;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flags_q.ovr & ovr_ie;
         end
         assign err_irq = irq_q;
      end else begin : g_irq_comb
         assign err_irq = flags_q.ovr & ovr_ie;
      end
   endgenerate
endmodule

// File: rtl/rx_status_flags_chk.sv
module rx_status_flags_chk #(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_done,
   input logic              idle_det,
   input logic              data_rd,
   input logic              ovr_ie,
   input logic              rx_full,
   input logic              overrun,
   input logic              idle,
   input logic [DATA_W-1:0] rx_data,
   input logic              err_irq
);
   AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && char_done && !data_rd) |=> (overrun && rx_full && $stable(rx_data))); // R1
   AST_OVR_CLR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overrun) |-> $past(data_rd)); // R2
   AST_IDLE_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> $past(idle_det)); // R4
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rx_full && !overrun && !idle)); // R5
   AST_FULL_CLR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(data_rd)); // R7
   AST_IDLE_CLR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle) |-> $past(data_rd)); // R8
   AST_NO_OVR_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!overrun && char_done && !rx_full) |=> (!overrun && rx_full)); // R11
   generate
      if (IRQ_REG) begin : g_reg
         AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            err_irq |-> $past(ovr_ie)); // R3
      end else begin : g_comb
         AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            err_irq |-> (overrun && ovr_ie)); // R3
      end
   endgenerate
endmodule

bind rx_status_flags rx_status_flags_chk #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .char_done(char_done), .idle_det(idle_det),
   .data_rd(data_rd), .ovr_ie(ovr_ie), .rx_full(rx_full), .overrun(overrun),
   .idle(idle), .rx_data(rx_data), .err_irq(err_irq));

// File: tb/rx_status_flags_tb_top.sv
module rx_status_flags_tb_top;
   localparam int DW = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic char_done = 0, idle_det = 0, stat_rd = 0, data_rd = 0, ovr_ie = 0;
   logic [DW-1:0] char_data = '0;
   logic rx_full, overrun, idle, err_irq;
   logic [DW-1:0] rx_data;

   int n_chk = 0;
   int n_fail = 0;

   // reference state built from the requirements
   logic m_full = 0, m_ovr = 0, m_idle = 0, m_ien = 0;
   logic m_af = 0, m_ao = 0, m_ai = 0;
   logic [DW-1:0] m_data = '0;

   always #2.5 clk = ~clk;

   rx_status_flags #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
      .idle_det(idle_det), .stat_rd(stat_rd), .data_rd(data_rd), .ovr_ie(ovr_ie),
      .rx_full(rx_full), .overrun(overrun), .idle(idle), .rx_data(rx_data),
      .err_irq(err_irq));

   function automatic logic exp_irq(input logic o, input logic ie);
      return o & ie;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_update();
      logic cf, co, ci, kept, ld;
      cf = data_rd & m_af; co = data_rd & m_ao; ci = data_rd & m_ai;
      kept = m_full & ~cf;
      ld = char_done & ~kept;
      if (!rst_n) begin
         m_full = 0; m_ovr = 0; m_idle = 0; m_ien = 0; m_data = '0;
         m_af = 0; m_ao = 0; m_ai = 0;
      end else begin
         if (stat_rd) begin m_af = m_full; m_ao = m_ovr; m_ai = m_idle; end
         else if (data_rd) begin m_af = 0; m_ao = 0; m_ai = 0; end
         m_ovr  = (m_ovr & ~co) | (char_done & kept);
         m_idle = (m_idle & ~ci) | (idle_det & m_ien);
         m_ien  = ld | (m_ien & ~idle_det);
         if (ld) m_data = char_data;
         m_full = kept | ld;
      end
   endtask

   task automatic compare_all(input string tag);
      check({tag, " full"}, 32'(rx_full), 32'(m_full));
      check({tag, " ovr"}, 32'(overrun), 32'(m_ovr));
      check({tag, " idle"}, 32'(idle), 32'(m_idle));
      check({tag, " data"}, 32'(rx_data), 32'(m_data));
      check({tag, " irq R3"}, 32'(err_irq), 32'(exp_irq(m_ovr, ovr_ie)));
   endtask

   // drive on negedge, update model at posedge, sample after it
   task automatic step(input string tag, input logic cd, input logic [DW-1:0] d,
                       input logic id, input logic sr, input logic dr);
      @(negedge clk);
      char_done = cd; char_data = d; idle_det = id; stat_rd = sr; data_rd = dr;
      @(posedge clk);
      model_update();
      #1;
      compare_all(tag);
      @(negedge clk);
      char_done = 0; idle_det = 0; stat_rd = 0; data_rd = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      step("R5 reset", 0, '0, 0, 0, 0);
      check("R5 full in reset", 32'(rx_full), 0);
      check("R5 ovr in reset", 32'(overrun), 0);
      check("R5 idle in reset", 32'(idle), 0);
      @(negedge clk); rst_n = 1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      do_reset();
      // R4: idle before any byte is ignored
      step("R4 idle unarmed", 0, '0, 1, 0, 0);
      check("R4 idle stays 0", 32'(idle), 0);
      // R11: byte load
      step("R11 load", 1, 8'hA5, 0, 0, 0);
      check("R11 data", 32'(rx_data), 32'hA5);
      check("R11 full", 32'(rx_full), 1);
      // R4: now armed
      step("R4 idle armed", 0, '0, 1, 0, 0);
      check("R4 idle set", 32'(idle), 1);
      // R1: overrun
      ovr_ie = 1;
      step("R1 overrun", 1, 8'h3C, 0, 0, 0);
      check("R1 ovr set", 32'(overrun), 1);
      check("R1 data kept", 32'(rx_data), 32'hA5);
      check("R3 irq on", 32'(err_irq), 1);
      ovr_ie = 0; #1;
      check("R3 irq gated off", 32'(err_irq), 0);
      // R2/R7/R8: clearing sequence
      step("R7 stat read", 0, '0, 0, 1, 0);
      step("R7 data read", 0, '0, 0, 0, 1);
      check("R7 full clear", 32'(rx_full), 0);
      check("R2 ovr clear", 32'(overrun), 0);
      check("R8 idle clear", 32'(idle), 0);
      // R6: delayed sequence
      step("R6 byte1", 1, 8'h11, 0, 0, 0);
      step("R6 stat", 0, '0, 0, 1, 0);
      step("R6 byte2 lost", 1, 8'h22, 0, 0, 0);
      step("R6 data read", 0, '0, 0, 0, 1);
      check("R6 older byte", 32'(rx_data), 32'h11);
      check("R6 ovr stays", 32'(overrun), 1);
      check("R2 ovr not cleared by unarmed read", 32'(overrun), 1);
      step("R6 byte3", 1, 8'h33, 0, 0, 0);
      check("R6 byte3 loaded", 32'(rx_data), 32'h33);
      step("R6 stat again", 0, '0, 0, 1, 0);
      // R9: second data read without status read
      step("R9 data read", 0, '0, 0, 0, 1);
      check("R6 ovr cleared", 32'(overrun), 0);
      step("R9 reload", 1, 8'h44, 0, 0, 0);
      step("R9 second data read", 0, '0, 0, 0, 1);
      check("R9 full kept", 32'(rx_full), 1);
      // R10: same-cycle clear and byte
      step("R10 stat", 0, '0, 0, 1, 0);
      step("R10 collide", 1, 8'h55, 0, 0, 1);
      check("R10 full", 32'(rx_full), 1);
      check("R10 no ovr", 32'(overrun), 0);
      check("R10 data", 32'(rx_data), 32'h55);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int unsigned r = $urandom;
         int unsigned bus = r[3:2];
         ovr_ie = r[4];
         step("RND", r[0] & r[5], 8'($urandom), r[1] & r[6], bus == 1, bus == 2);
         if (i == 1500) do_reset();
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule